// File: doc/BRIEF.md
# Tagged FIFO Inter-Thread Cell

This block is a single message cell that hardware threads use to pass data words to one another. The cell holds a small circular buffer of data words, a head index and a fill count. It also keeps an empty flag, a full flag and a trap flag. Every request carries a two-bit view selector taken from the address. The view decides how the same storage is seen. The raw view peeks at the data or patches it without moving any pointer. The tag view reads the packed status word, and writes the flag bits in it. The waiting view pushes and pops, and it refuses when the cell is empty or full. The try view pushes and pops but never refuses.

When a waiting access cannot complete, it gets a stall response, and the requesting thread's bit is set in a blocked-thread mask. Later, an access that does move data raises a one-cycle wake pulse that carries the whole mask, and the mask is then cleared. A scheduler outside the block uses the pulse to retry the parked threads.

Every request is answered exactly one clock later. There is no back-pressure on requests.

Top module: `itcell_fifo`

## Requirements
- R1: After reset the cell is in this state:
  - empty flag set, full flag clear, trap flag clear;
  - FIFO-mode bit set, count zero, head zero;
  - every data entry zero, blocked mask zero;
  - `rsp_valid` and `wake_valid` low.
- R2: `req_view` selects the view: 0 is raw, 1 is tag, 2 is waiting push/pop, 3 is try push/pop. A request taken on a clock edge gives `rsp_valid` high for exactly the following cycle. A write returns zero data.
- R3: A tag-view read returns a word laid out as follows. Every other bit is zero.
  - bits [31:28]: log2 of DEPTH;
  - bits 18 upward: the fill count, log2(DEPTH)+1 bits wide;
  - bit 17: the FIFO-mode bit, always 1;
  - bit 16: the trap flag;
  - bit 1: the full flag;
  - bit 0: the empty flag.
- R4: A tag-view write loads the trap flag from data bit 16, the empty flag from bit 0 and the full flag from bit 1. The depth code, the count, the FIFO-mode bit, the head and the data are unchanged.
- R5: A pop with a non-zero count does the following:
  - returns the entry at the head;
  - advances the head modulo DEPTH and decrements the count;
  - clears the full flag;
  - sets the empty flag when the count reaches zero.
- R6: A push with count below DEPTH does the following:
  - stores the word at (head + count) modulo DEPTH and increments the count;
  - clears the empty flag;
  - sets the full flag when the count reaches DEPTH.
- R7: The raw view never changes the pointers or the flags.
  - A raw read returns the entry at the head.
  - A raw write with a non-zero count overwrites the entry at (head + count − 1) modulo DEPTH.
  - A raw write with a zero count is ignored.
- R8: A try pop with zero count returns zero and changes nothing. A try push with count DEPTH is dropped. A waiting pop with the empty flag clear and zero count returns zero without stalling. None of these raises a wake.
- R9: A waiting pop while the empty flag is set, or a waiting push while the full flag is set, answers with `rsp_stall` high and zero data. It leaves the data, the pointers and the flags unchanged, and it sets bit `req_tid` of the blocked mask.
- R10: A push or pop that moves a word while the blocked mask is non-zero raises `wake_valid` for one cycle, with `wake_mask` equal to the mask. The mask is then zero. In all other cases `wake_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 2 | View-select address bits |
| req_tid | input | TID_W | Requesting thread number |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_stall | output | 1 | Waiting access refused, thread parked |
| rsp_rdata | output | DATA_W | Read data |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | 2**TID_W | Threads to wake |

## Verification
The bench builds the cell with DEPTH = 4 and the default 6-bit thread number. The small depth means that every fill level, the full boundary, the dropped try push and several wraps of the head index are all reached within a few dozen accesses. The wide thread number means all 64 thread bits can be parked one after another and released by one wake. Expected responses come from an arithmetic model of the buffer that is advanced access by access.

// File: rtl/itcell_pkg.sv
// Package: shared view encoding and tag-word bit positions for the FIFO cell.
// Assumes: the tag word fits in 32 bits of a data word at least 32 bits wide.
package itcell_pkg;

    typedef enum logic [1:0] {
        VW_RAW  = 2'd0,
        VW_TAG  = 2'd1,
        VW_WAIT = 2'd2,
        VW_TRY  = 2'd3
    } view_e;

    localparam int TAG_CODE_LSB = 28;
    localparam int TAG_CNT_LSB  = 18;
    localparam int TAG_MODE_BIT = 17;
    localparam int TAG_TRAP_BIT = 16;
    localparam int TAG_FULL_BIT = 1;
    localparam int TAG_EMPT_BIT = 0;

endpackage

// File: rtl/itcell_store.sv
// Module: data array of the cell; one synchronous write port, one
// combinational read port addressed by the head index.
// Assumes: DEPTH is a power of two, at least 2.
module itcell_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear all entries on reset, otherwise take the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Present the entry at the requested index.
    assign rdata = mem[ridx];

endmodule

// File: rtl/itcell_ctrl.sv
// Module: view decoder and state of the cell: head, count, flags,
// blocked-thread mask, registered response and wake pulse.
// Assumes: one request per cycle, answered one cycle later; DEPTH a power of two.
module itcell_ctrl
    import itcell_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int TID_W  = 6,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1,
    localparam int MASK_W = 1 << TID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  view_e             req_view,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] store_rdata,
    output logic              store_we,
    output logic [PTR_W-1:0]  store_widx,
    output logic [PTR_W-1:0]  head_idx,
    output logic              rsp_valid,
    output logic              rsp_stall,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wake_valid,
    output logic [MASK_W-1:0] wake_mask
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [3:0]       DCODE    = 4'(PTR_W);

    logic [PTR_W-1:0]  head, head_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              e_flag, e_n, f_flag, f_n, t_flag, t_n;
    logic [MASK_W-1:0] blk_mask, mask_n, wmask_n;
    logic              stall_n, wake_n, moved, blocking;
    logic [DATA_W-1:0] rdata_n, tag_word;
    logic [PTR_W-1:0]  cnt_lo;

    assign cnt_lo   = cnt[PTR_W-1:0];
    assign head_idx = head;
    assign blocking = (req_view == VW_WAIT);

    // Pack the status word seen through the tag view.
    always_comb begin
        tag_word = '0;
        tag_word[TAG_CODE_LSB +: 4]     = DCODE;
        tag_word[TAG_CNT_LSB +: CNT_W]  = cnt;
        tag_word[TAG_MODE_BIT]          = 1'b1;
        tag_word[TAG_TRAP_BIT]          = t_flag;
        tag_word[TAG_FULL_BIT]          = f_flag;
        tag_word[TAG_EMPT_BIT]          = e_flag;
    end

    // Decode the request against the selected view and form the next state.
    always_comb begin
        head_n     = head;
        cnt_n      = cnt;
        e_n        = e_flag;
        f_n        = f_flag;
        t_n        = t_flag;
        mask_n     = blk_mask;
        wmask_n    = '0;
        wake_n     = 1'b0;
        stall_n    = 1'b0;
        moved      = 1'b0;
        rdata_n    = '0;
        store_we   = 1'b0;
        store_widx = head + cnt_lo;
        if (req_valid) begin
            unique case (req_view)
                VW_RAW: begin
                    if (req_write) begin
                        store_widx = head + cnt_lo - PTR_W'(1);
                        store_we   = (cnt != '0);
                    end else begin
                        rdata_n = store_rdata;
                    end
                end
                VW_TAG: begin
                    if (req_write) begin
                        t_n = req_wdata[TAG_TRAP_BIT];
                        e_n = req_wdata[TAG_EMPT_BIT];
                        f_n = req_wdata[TAG_FULL_BIT];
                    end else begin
                        rdata_n = tag_word;
                    end
                end
                default: begin
                    if (!req_write) begin
                        if (blocking && e_flag) begin
                            stall_n = 1'b1;
                        end else if (cnt != '0) begin
                            rdata_n = store_rdata;
                            head_n  = head + PTR_W'(1);
                            cnt_n   = cnt - CNT_ONE;
                            f_n     = 1'b0;
                            e_n     = (cnt == CNT_ONE) ? 1'b1 : e_flag;
                            moved   = 1'b1;
                        end
                    end else begin
                        if (blocking && f_flag) begin
                            stall_n = 1'b1;
                        end else if (cnt != CNT_FULL) begin
                            store_we = 1'b1;
                            cnt_n    = cnt + CNT_ONE;
                            e_n      = 1'b0;
                            f_n      = (cnt == CNT_FULL - CNT_ONE) ? 1'b1 : f_flag;
                            moved    = 1'b1;
                        end
                    end
                    if (stall_n) begin
                        mask_n = blk_mask | (MASK_W'(1) << req_tid);
                    end else if (moved && (blk_mask != '0)) begin
                        wake_n  = 1'b1;
                        wmask_n = blk_mask;
                        mask_n  = '0;
                    end
                end
            endcase
        end
    end

    // Register cell state, response and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head       <= '0;
            cnt        <= '0;
            e_flag     <= 1'b1;
            f_flag     <= 1'b0;
            t_flag     <= 1'b0;
            blk_mask   <= '0;
            rsp_valid  <= 1'b0;
            rsp_stall  <= 1'b0;
            rsp_rdata  <= '0;
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else begin
            head       <= head_n;
            cnt        <= cnt_n;
            e_flag     <= e_n;
            f_flag     <= f_n;
            t_flag     <= t_n;
            blk_mask   <= mask_n;
            rsp_valid  <= req_valid;
            rsp_stall  <= stall_n;
            rsp_rdata  <= rdata_n;
            wake_valid <= wake_n;
            wake_mask  <= wmask_n;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);                                                   // R6
    AST_FILL_SETS_F: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_FULL && $past(cnt) == CNT_FULL - CNT_ONE) |-> f_flag);  // R6
    AST_DRAIN_SETS_E: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && $past(cnt) == CNT_ONE) |-> e_flag);                   // R5
    AST_STALL_HOLDS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (cnt == $past(cnt) && head == $past(head)));          // R9
    AST_STALL_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (blk_mask != '0));                                    // R9
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (blk_mask == '0 && wake_mask != '0));                // R10
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid || $past(req_valid));                    // R10

endmodule

// File: rtl/itcell_fifo.sv
// Module: top of the tagged FIFO inter-thread cell; joins the view/state
// controller to the data array.
// Assumes: DEPTH is a power of two, 2..512; DATA_W at least 32.
module itcell_fifo
    import itcell_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int TID_W  = 6,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int MASK_W = 1 << TID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_view,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_stall,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wake_valid,
    output logic [MASK_W-1:0] wake_mask
);

    logic              st_we;
    logic [PTR_W-1:0]  st_widx, st_ridx;
    logic [DATA_W-1:0] st_rdata;

    itcell_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TID_W(TID_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_view   (view_e'(req_view)),
        .req_tid    (req_tid),
        .req_wdata  (req_wdata),
        .store_rdata(st_rdata),
        .store_we   (st_we),
        .store_widx (st_widx),
        .head_idx   (st_ridx),
        .rsp_valid  (rsp_valid),
        .rsp_stall  (rsp_stall),
        .rsp_rdata  (rsp_rdata),
        .wake_valid (wake_valid),
        .wake_mask  (wake_mask)
    );

    itcell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .widx (st_widx),
        .wdata(req_wdata),
        .ridx (st_ridx),
        .rdata(st_rdata)
    );

endmodule

// File: tb/itcell_fifo_tb_top.sv
// Bench: drives views against an arithmetic model of a 4-entry cell.
module itcell_fifo_tb_top;

    localparam int D  = 4;
    localparam int DW = 64;
    localparam int TW = 6;
    localparam int MW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [1:0]    req_view;
    logic [TW-1:0] req_tid;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid, rsp_stall, wake_valid;
    logic [DW-1:0] rsp_rdata;
    logic [MW-1:0] wake_mask;

    itcell_fifo #(.DEPTH(D), .DATA_W(DW), .TID_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [DW-1:0] m_data [D];
    int            m_head, m_cnt;
    bit            m_e, m_f, m_t;
    logic [MW-1:0] m_mask;

    function automatic logic [DW-1:0] tag_exp();
        return (64'(2) << 28) | (64'(m_cnt) << 18) | (64'(1) << 17) |
               (64'(m_t) << 16) | (64'(m_f) << 1) | 64'(m_e);
    endfunction

    task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    // One access: update the model, drive for one cycle, compare the response.
    task automatic acc(input bit wr, input logic [1:0] v, input int tid,
                       input logic [DW-1:0] wd, input string r);
        bit            st = 0, mv = 0, wk = 0;
        logic [DW-1:0] rd = '0;
        logic [MW-1:0] wm = '0;
        case (v)
            2'd0: if (wr) begin
                      if (m_cnt != 0) m_data[(m_head + m_cnt - 1) % D] = wd;
                  end else rd = m_data[m_head];
            2'd1: if (wr) begin
                      m_t = wd[16]; m_e = wd[0]; m_f = wd[1];
                  end else rd = tag_exp();
            default: begin
                if (!wr) begin
                    if (v == 2 && m_e) st = 1;
                    else if (m_cnt > 0) begin
                        rd = m_data[m_head]; m_head = (m_head + 1) % D;
                        m_cnt--; m_f = 0; if (m_cnt == 0) m_e = 1; mv = 1;
                    end
                end else begin
                    if (v == 2 && m_f) st = 1;
                    else if (m_cnt < D) begin
                        m_data[(m_head + m_cnt) % D] = wd; m_cnt++;
                        m_e = 0; if (m_cnt == D) m_f = 1; mv = 1;
                    end
                end
                if (st) m_mask[tid] = 1'b1;
                else if (mv && m_mask != '0) begin
                    wk = 1; wm = m_mask; m_mask = '0;
                end
            end
        endcase
        req_valid = 1; req_write = wr; req_view = v; req_tid = TW'(tid); req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk({r, " rsp_valid (R2)"}, 64'(rsp_valid), 64'(1));
        chk({r, " stall"},          64'(rsp_stall), 64'(st));
        chk({r, " rdata"},          rsp_rdata, rd);
        chk({r, " wake_valid"},     64'(wake_valid), 64'(wk));
        chk({r, " wake_mask"},      wake_mask, wm);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_view = 0; req_tid = 0; req_wdata = 0;
        for (int i = 0; i < D; i++) m_data[i] = '0;
        m_head = 0; m_cnt = 0; m_e = 1; m_f = 0; m_t = 0; m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rsp_valid idle", 64'(rsp_valid), 64'(0));
        chk("R1 wake idle", 64'(wake_valid), 64'(0));
        acc(0, 1, 0, 0, "R1 R3 reset tag");
        acc(0, 0, 0, 0, "R1 reset data");
        // R7: raw write with zero count ignored
        acc(1, 0, 0, 64'hDEAD, "R7 raw wr empty");
        acc(0, 0, 0, 0, "R7 raw rd after ignored wr");
        // R6: fill every level
        for (int i = 0; i < D; i++) begin
            acc(1, 3, 0, 64'(100 + i), "R6 push");
            acc(0, 1, 0, 0, "R3 R6 tag level");
        end
        acc(1, 3, 0, 64'hBAD, "R8 try push full");
        acc(0, 1, 0, 0, "R8 tag after drop");
        acc(0, 0, 0, 0, "R7 raw rd head");
        acc(1, 0, 0, 64'h777, "R7 raw overwrite newest");
        acc(0, 1, 0, 0, "R7 tag unchanged");
        for (int i = 0; i <= D; i++) acc(0, 3, 0, 0, "R5 R8 drain");
        acc(0, 1, 0, 0, "R8 tag after empty try");
        // R5 R6: wrap the head several times
        for (int rnd = 0; rnd < 6; rnd++) begin
            for (int k = 0; k < 3; k++) acc(1, 3, rnd, 64'(rnd * 16 + k), "R6 wrap push");
            for (int k = 0; k < 2; k++) acc(0, 3, rnd, 0, "R5 wrap pop");
            acc(0, 1, 0, 0, "R3 wrap tag");
        end
        while (m_cnt > 0) acc(0, 2, 0, 0, "R5 waiting drain");
        // R9 R10: park every thread on an empty cell, release with one push
        for (int t = 0; t < MW; t++) acc(0, 2, t, 0, "R9 park reader");
        acc(0, 1, 0, 0, "R9 tag after stalls");
        acc(1, 2, 0, 64'h55, "R10 wake all");
        acc(0, 3, 0, 0, "R10 no second wake");
        for (int i = 0; i < D; i++) acc(1, 3, 1, 64'(200 + i), "R6 refill");
        acc(1, 2, 5, 64'h1, "R9 park writer 5");
        acc(1, 2, 9, 64'h2, "R9 park writer 9");
        acc(0, 0, 0, 0, "R9 data kept");
        acc(0, 2, 0, 0, "R10 wake writers");
        // R4: tag writes touch only the three flags
        acc(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 set flags");
        acc(0, 1, 0, 0, "R4 tag readback");
        acc(1, 1, 0, 64'h0, "R4 clear flags");
        acc(0, 1, 0, 0, "R4 tag cleared");
        while (m_cnt > 0) acc(0, 2, 0, 0, "R5 drain again");
        acc(1, 1, 0, 64'h0, "R4 clear empty");
        acc(0, 2, 7, 0, "R8 waiting pop no data");
        acc(1, 1, 0, 64'h2, "R4 force full");
        acc(1, 2, 3, 64'h9, "R9 stall on forced full");
        acc(1, 3, 0, 64'hA, "R10 try push wakes");
        acc(0, 1, 0, 0, "R4 tag final");
        acc(0, 0, 0, 0, "R7 raw final");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule